// File: doc/BRIEF.md
# Frequent Pattern Word Compressor

This block turns one 32-bit data word per accepted transfer into a short code: a 3-bit prefix that names the value pattern the word belongs to, plus a payload of 0, 4, 8, 16 or 32 bits. The payload is the part of the word that the pattern cannot infer. Common values such as zero, small signed integers, half-aligned constants and repeated bytes get short codes. Any other word is passed through whole behind a raw prefix.

The encode side takes a valid/ready word stream and returns the prefix, the payload and the payload length one cycle later. It holds these outputs while the consumer stalls. A purely combinational expand side takes any prefix and payload pair and rebuilds the original word. A line packer can therefore place codes in a bitstream, and a reader can restore the words from it.

Top module: `fpc_word_codec`

## Requirements
- R1: A word equal to zero is coded with prefix 000, payload 0 and length 0.
- R2: A word whose signed value lies in -8..7 is coded with prefix 001; the payload holds its low 4 bits in payload[3:0].
- R3: A word whose signed value lies in -128..127 is coded with prefix 010, with the low byte in payload[7:0]. A word made of four equal bytes that is not in that range is coded with prefix 110, with the byte in payload[7:0].
- R4: A 16-bit signed word (range -32768..32767) uses prefix 011 with payload[15:0] = word[15:0]. A word whose low half is zero uses prefix 100 with payload[15:0] = word[31:16]. A word whose two halves are each a sign-extended byte uses prefix 101, with payload[15:8] = word[23:16] and payload[7:0] = word[7:0].
- R5: A word that fits no pattern is coded with prefix 111 and the whole word as payload.
- R6: When several patterns fit, the one with the shortest payload wins, and among equal lengths the lower prefix wins.
- R7: The length output is 0 for prefix 000, 4 for 001, 8 for 010 and 110, 16 for 011, 100 and 101, and 32 for 111.
- R8: Payload bits at and above the reported length are zero.
- R9: A word accepted on a clock edge (in_valid and in_ready high) appears on the outputs with out_valid high right after that edge.
- R10: While out_valid is high and out_ready is low, out_valid, out_prefix, out_payload and out_len stay unchanged.
- R11: in_ready is high exactly when no code is held or the held code is being taken (out_ready high).
- R12: For every prefix and payload that the encoder produces, dec_word equals the original word in the same cycle.
- R13: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 32 | Word to compress |
| out_valid | output | 1 | A code is held on the outputs |
| out_ready | input | 1 | Consumer takes the held code |
| out_prefix | output | 3 | Pattern prefix of the held code |
| out_payload | output | 32 | Payload, right-aligned, unused bits zero |
| out_len | output | 6 | Payload length in bits |
| dec_prefix | input | 3 | Prefix to expand |
| dec_payload | input | 32 | Payload to expand |
| dec_word | output | 32 | Rebuilt word |

## Verification
An error in the output register or the stall logic shows on the very next edge. A held code would drift during backpressure, or a code would be lost or repeated when out_valid and in_ready disagree with the transfer history. A wrong pattern choice shows in the cycle after acceptance as a longer code than needed or a wrong prefix. A payload that drops bits shows at once as a mismatch on the expand side. The bench runs a behavioural model of both sides on every clock and checks these points with a random consumer stall pattern.

// File: rtl/fpc_pkg.sv
// Shared definitions for the frequent pattern word codec.
// Assumes a 32-bit word and a fixed 3-bit prefix; the pattern set is fixed.
package fpc_pkg;
    localparam int WORD_W = 32;
    localparam int PFX_W  = 3;
    localparam int LEN_W  = $clog2(WORD_W) + 1;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = 8;

    typedef enum logic [PFX_W-1:0] {
        PFX_ZERO     = 3'd0,
        PFX_SX4      = 3'd1,
        PFX_SX8      = 3'd2,
        PFX_SX16     = 3'd3,
        PFX_HI_HALF  = 3'd4,
        PFX_TWO_SXB  = 3'd5,
        PFX_REP_BYTE = 3'd6,
        PFX_RAW      = 3'd7
    } pfx_e;

    // Payload length in bits for each prefix.
    function automatic logic [LEN_W-1:0] pfx_len(input pfx_e p);
        case (p)
            PFX_ZERO:                         return LEN_W'(0);
            PFX_SX4:                          return LEN_W'(4);
            PFX_SX8, PFX_REP_BYTE:            return LEN_W'(8);
            PFX_SX16, PFX_HI_HALF, PFX_TWO_SXB: return LEN_W'(16);
            default:                          return LEN_W'(WORD_W);
        endcase
    endfunction

    // Rebuild a word from a prefix and its right-aligned payload.
    function automatic logic [WORD_W-1:0] fpc_expand(input pfx_e p,
                                                     input logic [WORD_W-1:0] pl);
        case (p)
            PFX_ZERO:     return '0;
            PFX_SX4:      return {{(WORD_W-4){pl[3]}}, pl[3:0]};
            PFX_SX8:      return {{(WORD_W-8){pl[7]}}, pl[7:0]};
            PFX_SX16:     return {{(WORD_W-16){pl[15]}}, pl[15:0]};
            PFX_HI_HALF:  return {pl[HALF_W-1:0], {HALF_W{1'b0}}};
            PFX_TWO_SXB:  return {{(HALF_W-BYTE_W){pl[15]}}, pl[15:8],
                                  {(HALF_W-BYTE_W){pl[7]}}, pl[7:0]};
            PFX_REP_BYTE: return {(WORD_W/BYTE_W){pl[BYTE_W-1:0]}};
            default:      return pl;
        endcase
    endfunction
endpackage

// File: rtl/fpc_classifier.sv
// Combinational pattern matcher and code builder.
// Tests the word against every pattern and keeps the shortest match, with the
// lower prefix winning a tie. Assumes a stable word input within the cycle.
module fpc_classifier
    import fpc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output pfx_e              pfx_o,
    output logic [WORD_W-1:0] payload_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam int NPAT = 1 << PFX_W;
    localparam int NSX  = 3;
    // Prefixes listed from shortest payload to longest, lower prefix first.
    localparam logic [PFX_W-1:0] RANK [NPAT] =
        '{3'd0, 3'd1, 3'd2, 3'd6, 3'd3, 3'd4, 3'd5, 3'd7};

    logic [NPAT-1:0] match;

    // Sign-extension patterns of width 4, 8 and 16: upper bits all equal.
    for (genvar g = 0; g < NSX; g++) begin : g_sx
        localparam int W = 4 << g;
        assign match[g+1] = (&word_i[WORD_W-1:W-1]) | ~(|word_i[WORD_W-1:W-1]);
    end

    // Remaining patterns: zero, low half zero, two signed bytes, repeated byte, raw.
    always_comb begin
        match[0] = (word_i == '0);
        match[4] = (word_i[HALF_W-1:0] == '0);
        match[5] = ((&word_i[WORD_W-1:HALF_W+BYTE_W-1]) | ~(|word_i[WORD_W-1:HALF_W+BYTE_W-1]))
                 & ((&word_i[HALF_W-1:BYTE_W-1]) | ~(|word_i[HALF_W-1:BYTE_W-1]));
        match[6] = (word_i == {(WORD_W/BYTE_W){word_i[BYTE_W-1:0]}});
        match[7] = 1'b1;
    end

    // Pick the first matching pattern in rank order.
    always_comb begin
        pfx_o = PFX_RAW;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (match[RANK[i]]) pfx_o = pfx_e'(RANK[i]);
        end
    end

    // Extract the payload for the chosen pattern, unused bits zero.
    always_comb begin
        payload_o = '0;
        case (pfx_o)
            PFX_ZERO:     payload_o = '0;
            PFX_SX4:      payload_o[3:0] = word_i[3:0];
            PFX_SX8:      payload_o[7:0] = word_i[7:0];
            PFX_SX16:     payload_o[15:0] = word_i[15:0];
            PFX_HI_HALF:  payload_o[HALF_W-1:0] = word_i[WORD_W-1:HALF_W];
            PFX_TWO_SXB:  payload_o[15:0] = {word_i[HALF_W+BYTE_W-1:HALF_W], word_i[BYTE_W-1:0]};
            PFX_REP_BYTE: payload_o[BYTE_W-1:0] = word_i[BYTE_W-1:0];
            default:      payload_o = word_i;
        endcase
    end

    // Length follows the chosen prefix.
    always_comb len_o = pfx_len(pfx_o);
endmodule

// File: rtl/fpc_expander.sv
// Combinational decoder: prefix plus payload back to the 32-bit word.
// Assumes the payload is right-aligned; bits above the pattern length are ignored.
module fpc_expander
    import fpc_pkg::*;
(
    input  logic [PFX_W-1:0]  pfx_i,
    input  logic [WORD_W-1:0] payload_i,
    output logic [WORD_W-1:0] word_o
);
    // Rebuild the word with the shared expansion rule.
    always_comb word_o = fpc_expand(pfx_e'(pfx_i), payload_i);
endmodule

// File: rtl/fpc_word_codec.sv
// Top of the frequent pattern codec: a one-stage registered encoder on a
// valid/ready stream and an independent combinational expander.
// Assumes synchronous active-low reset; outputs hold while out_ready is low.
module fpc_word_codec
    import fpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PFX_W-1:0]  out_prefix,
    output logic [WORD_W-1:0] out_payload,
    output logic [LEN_W-1:0]  out_len,
    input  logic [PFX_W-1:0]  dec_prefix,
    input  logic [WORD_W-1:0] dec_payload,
    output logic [WORD_W-1:0] dec_word
);
    pfx_e              cls_pfx;
    logic [WORD_W-1:0] cls_payload;
    logic [LEN_W-1:0]  cls_len;
    logic              valid_q;
    pfx_e              pfx_q;
    logic [WORD_W-1:0] payload_q;
    logic [LEN_W-1:0]  len_q;

    fpc_classifier u_cls (
        .word_i    (in_word),
        .pfx_o     (cls_pfx),
        .payload_o (cls_payload),
        .len_o     (cls_len)
    );

    fpc_expander u_exp (
        .pfx_i     (dec_prefix),
        .payload_i (dec_payload),
        .word_o    (dec_word)
    );

    // Stage is free when empty or drained this cycle.
    always_comb in_ready = !valid_q || out_ready;

    // Output register: load on acceptance, clear on drain, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            pfx_q     <= PFX_ZERO;
            payload_q <= '0;
            len_q     <= '0;
        end else if (in_ready) begin
            valid_q <= in_valid;
            if (in_valid) begin
                pfx_q     <= cls_pfx;
                payload_q <= cls_payload;
                len_q     <= cls_len;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_prefix  = pfx_q;
    assign out_payload = payload_q;
    assign out_len     = len_q;

    // R9: an accepted word is presented on the next cycle.
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R10: a stalled code does not move.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_prefix)
            && $stable(out_payload) && $stable(out_len));

    // R11: a drained code with nothing new leaves the stage empty.
    p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    // R7: only the five legal lengths appear.
    p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len inside {6'd0, 6'd4, 6'd8, 6'd16, 6'd32}));

    // R8: no payload bits beyond the reported length.
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_payload >> out_len) == '0));

    // R12: the chosen code expands back to the word being accepted.
    p_roundtrip_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> (fpc_expand(cls_pfx, cls_payload) == in_word));
endmodule

// File: tb/fpc_word_codec_tb.sv
`timescale 1ns/1ps
module fpc_word_codec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        out_valid;
    logic        out_ready;
    logic [2:0]  out_prefix;
    logic [31:0] out_payload;
    logic [5:0]  out_len;
    logic [2:0]  dec_prefix;
    logic [31:0] dec_payload;
    logic [31:0] dec_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Behavioural model state
    bit          m_valid = 0;
    logic [2:0]  m_pfx;
    logic [31:0] m_pl;
    int          m_len;
    int          m_nmatch;
    bit          m_stalled = 0;

    always #2.5 clk = ~clk;

    fpc_word_codec dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_prefix(out_prefix), .out_payload(out_payload), .out_len(out_len),
        .dec_prefix(dec_prefix), .dec_payload(dec_payload), .dec_word(dec_word)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference encoder from the requirement text: shortest fit, lower prefix on tie.
    task automatic ref_encode(input logic [31:0] w, output logic [2:0] p,
                              output logic [31:0] pl, output int len, output int nm);
        int lens [8] = '{0, 4, 8, 16, 16, 16, 8, 32};
        bit fit [8];
        int sv = $signed(w);
        int hi = $signed(w[31:16]);
        int lo = $signed(w[15:0]);
        fit[0] = (w == 0);
        fit[1] = (sv >= -8 && sv <= 7);
        fit[2] = (sv >= -128 && sv <= 127);
        fit[3] = (sv >= -32768 && sv <= 32767);
        fit[4] = (w[15:0] == 0);
        fit[5] = (hi >= -128 && hi <= 127 && lo >= -128 && lo <= 127);
        fit[6] = (w[31:24] == w[7:0] && w[23:16] == w[7:0] && w[15:8] == w[7:0]);
        fit[7] = 1;
        len = 99; p = 7; nm = 0;
        for (int i = 0; i < 8; i++) begin
            if (fit[i]) nm++;
            if (fit[i] && lens[i] < len) begin len = lens[i]; p = 3'(i); end
        end
        case (p)
            0: pl = 0;
            1: pl = {28'd0, w[3:0]};
            2: pl = {24'd0, w[7:0]};
            3: pl = {16'd0, w[15:0]};
            4: pl = {16'd0, w[31:16]};
            5: pl = {16'd0, w[23:16], w[7:0]};
            6: pl = {24'd0, w[7:0]};
            default: pl = w;
        endcase
    endtask

    function automatic string tag_of(input logic [2:0] p, input int nm);
        if (nm > 2) return "R6";
        case (p)
            0: return "R1";
            1: return "R2";
            2, 6: return "R3";
            3, 4, 5: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One cycle: drive at negedge, check comb paths, advance model, check registered outputs.
    task automatic step(input bit v, input logic [31:0] w, input bit rdy);
        logic [2:0] p; logic [31:0] pl; int len, nm;
        bit acc;
        in_valid = v; in_word = w; out_ready = rdy;
        ref_encode(w, p, pl, len, nm);
        dec_prefix = p; dec_payload = pl;
        #1;
        chk(in_ready == (!m_valid || rdy), "R11 in_ready", in_ready, !m_valid || rdy);
        chk(dec_word == w, "R12 dec_word", dec_word, w);
        acc = v && (!m_valid || rdy);
        m_stalled = m_valid && !rdy;
        if (acc) begin
            m_valid = 1; m_pfx = p; m_pl = pl; m_len = len; m_nmatch = nm;
        end else if (rdy) m_valid = 0;
        @(negedge clk);
        chk(out_valid == m_valid, m_stalled ? "R10 out_valid" : "R9 out_valid", out_valid, m_valid);
        if (m_valid) begin
            chk(out_prefix == m_pfx, m_stalled ? "R10 prefix" : tag_of(m_pfx, m_nmatch), out_prefix, m_pfx);
            chk(out_payload == m_pl, m_stalled ? "R10 payload" : "R8 payload", out_payload, m_pl);
            chk(int'(out_len) == m_len, "R7 len", out_len, m_len);
        end
    endtask

    function automatic logic [31:0] rnd_word();
        int k = $urandom_range(0, 7);
        case (k)
            0: return 0;
            1: return 32'($signed($urandom_range(0, 15)) - 8);
            2: return 32'($signed($urandom_range(0, 255)) - 128);
            3: return 32'($signed($urandom_range(0, 65535)) - 32768);
            4: return {16'($urandom), 16'd0};
            5: return {{8{1'($urandom)}}, 8'($urandom), {8{1'($urandom)}}, 8'($urandom)};
            6: return {4{8'($urandom)}};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        logic [31:0] dir [22] = '{32'h0, 32'h1, 32'h7, 32'h8, 32'hFFFFFFF8, 32'hFFFFFFFF,
                                 32'h7F, 32'hFFFFFF80, 32'h80, 32'h7FFF, 32'hFFFF8000,
                                 32'h8000, 32'h12340000, 32'h00120034, 32'hFF80007F,
                                 32'h05050505, 32'h80808080, 32'h12345678, 32'h80000000,
                                 32'h0000FFFF, 32'hFF00FF00, 32'h00010000};
        rst_n = 0; in_valid = 0; in_word = 0; out_ready = 0;
        dec_prefix = 0; dec_payload = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R13 out_valid in reset", out_valid, 0);
        chk(in_ready == 1, "R13 in_ready in reset", in_ready, 1);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R13 out_valid after reset", out_valid, 0);
        foreach (dir[i]) step(1, dir[i], 1);
        // Stall on a held code, then release (R10, R11).
        step(1, 32'h00000003, 0);
        step(1, 32'hDEADBEEF, 0);
        step(0, 32'h0, 0);
        step(1, 32'hDEADBEEF, 1);
        step(0, 32'h0, 1);
        step(0, 32'h0, 1);
        for (int i = 0; i < 4000; i++)
            step($urandom_range(0, 3) != 0, rnd_word(), $urandom_range(0, 9) < 7);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule